// File: doc/BRIEF.md
# Card Access Tick Generator

This block sets the pace of accesses to two removable card slots. Each slot has three address spaces: I/O, attribute and common memory. A 32-bit timing word holds six 5-bit divisors, one for each slot and space pair. When an access begins, the block reads the slot and space of that access, picks the matching divisor and latches it. For as long as the access lasts, it raises a single-cycle enable once every (divisor + 1) clocks. An external access sequencer steps forward on that enable. The enable is never used as a clock.

The card's wait line is asynchronous and is not tied to the enable cadence. The block passes it through a two-flop synchronizer and presents the result as a registered output. Software loads the timing word through a plain write port, and the stored word can be read back on the same port. Reset leaves the timing word untouched, so software must load it before the first access.

Top module: `cardtick_gen`

## Requirements
- R1: The divisor for slot code s (0 or 1) and space code p sits at bits [s*16 + p*5 +: 5] of the timing word. The space codes are 0 for I/O, 1 for attribute and 2 for common memory.
- R2: When the write enable is high on a clock edge, the timing word takes the write data. Bits 15 and 31 always read back as 0. The read data reflects the stored word from the cycle after the write edge onward.
- R3: Reset leaves the timing word unchanged. It does clear the tick enable, the access-active state and the synchronized wait output to 0.
- R4: On an accepted access start, the divisor is the field selected by the access's slot and space. The field is taken from the word as it stood before any write on that same edge.
- R5: While an access is active with latched divisor d, the tick enable is high for one cycle every d+1 cycles. The first tick is high in the (d+1)-th cycle after the start edge. With d=0 the tick is high every cycle.
- R6: Writes to the timing word during an active access do not change that access's tick period.
- R7: No tick occurs while no access is active. The tick is low in the cycle after an access-end edge.
- R8: A start while an access is already active restarts the access with the newly selected divisor and a cleared count. If start and end arrive on the same edge, start wins.
- R9: A start with space code 3 is ignored. No access begins and no tick follows.
- R10: The synchronized wait output equals the wait input as it was sampled two clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset (does not touch the timing word) |
| cfg_wr_en | input | 1 | Timing word write enable |
| cfg_wdata | input | 32 | Timing word write data |
| cfg_rdata | output | 32 | Stored timing word, reserved bits zero |
| acc_start | input | 1 | Access begins this cycle |
| acc_end | input | 1 | Access ends this cycle |
| acc_slot | input | 1 | Slot code of the access |
| acc_space | input | 2 | Space code of the access (0 I/O, 1 attribute, 2 common, 3 invalid) |
| card_wait_in | input | 1 | Asynchronous card wait line |
| tick_en | output | 1 | One-cycle enable for the access sequencer |
| card_wait_out | output | 1 | Synchronized wait line |

## Verification
The assertions assume three things. The timing word is written at least once before the first accepted start. Start and end are single-cycle pulses sampled on the rising edge. The wait input changes only away from the clock edge, which is why synchronizer metastability is not modeled. The stimulus follows all three: it loads the timing word before any access is started, drives every input at the falling edge, and toggles the wait line only at that point.

// File: rtl/cardtick_pkg.sv
package cardtick_pkg;

  localparam int CT_FIELD_W    = 5;
  localparam int CT_N_SPACE    = 3;
  localparam int CT_N_SLOT     = 2;
  localparam int CT_SYNC_DEPTH = 2;

  // one spare bit after each slot's group of fields
  localparam int CT_STRIDE = CT_N_SPACE * CT_FIELD_W + 1;
  localparam int CT_REG_W  = CT_N_SLOT * CT_STRIDE;

  typedef enum logic [1:0] {
    SPC_IO     = 2'd0,
    SPC_ATTR   = 2'd1,
    SPC_COMMON = 2'd2,
    SPC_BAD    = 2'd3
  } space_e;

endpackage

// File: rtl/cardtick_cfg_reg.sv
module cardtick_cfg_reg #(
  parameter int FIELD_W = cardtick_pkg::CT_FIELD_W,
  parameter int N_SPACE = cardtick_pkg::CT_N_SPACE,
  parameter int N_SLOT  = cardtick_pkg::CT_N_SLOT,
  localparam int STRIDE = N_SPACE * FIELD_W + 1,
  localparam int REG_W  = N_SLOT * STRIDE
) (
  input  logic                                      clk,
  input  logic                                      wr_en,
  input  logic [REG_W-1:0]                          wdata,
  output logic [REG_W-1:0]                          rdata,
  output logic [N_SLOT-1:0][N_SPACE-1:0][FIELD_W-1:0] fields
);

  function automatic logic [REG_W-1:0] field_mask();
    logic [REG_W-1:0] m;
    m = '0;
    for (int s = 0; s < N_SLOT; s++) begin
      for (int p = 0; p < N_SPACE; p++) begin
        m[s*STRIDE + p*FIELD_W +: FIELD_W] = '1;
      end
    end
    return m;
  endfunction

  localparam logic [REG_W-1:0] WR_MASK = field_mask();

  // deliberately no reset: contents survive a reset
  logic [REG_W-1:0] word_q;

  always_ff @(posedge clk) begin
    if (wr_en) word_q <= wdata & WR_MASK;
  end

  assign rdata = word_q;

  for (genvar gs = 0; gs < N_SLOT; gs++) begin : g_slot
    for (genvar gp = 0; gp < N_SPACE; gp++) begin : g_space
      assign fields[gs][gp] = word_q[gs*STRIDE + gp*FIELD_W +: FIELD_W];
    end
  end

  // R2: a write lands masked and is visible the next cycle
  a_r2_write_lands: assert property (@(posedge clk)
    wr_en |=> rdata == ($past(wdata) & WR_MASK));

endmodule

// File: rtl/cardtick_field_sel.sv
module cardtick_field_sel #(
  parameter int FIELD_W = cardtick_pkg::CT_FIELD_W,
  parameter int N_SPACE = cardtick_pkg::CT_N_SPACE,
  parameter int N_SLOT  = cardtick_pkg::CT_N_SLOT,
  localparam int SLOT_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int SPACE_W = $clog2(N_SPACE + 1)
) (
  input  logic [N_SLOT-1:0][N_SPACE-1:0][FIELD_W-1:0] fields,
  input  logic [SLOT_W-1:0]                           slot,
  input  logic [SPACE_W-1:0]                          space,
  output logic [FIELD_W-1:0]                          div,
  output logic                                        valid
);

  always_comb begin
    div   = '0;
    valid = 1'b0;
    for (int s = 0; s < N_SLOT; s++) begin
      for (int p = 0; p < N_SPACE; p++) begin
        if (slot == SLOT_W'(s) && space == SPACE_W'(p)) begin
          div   = fields[s][p];
          valid = 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/cardtick_rate_gen.sv
module cardtick_rate_gen #(
  parameter int FIELD_W = cardtick_pkg::CT_FIELD_W
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start,
  input  logic               stop,
  input  logic [FIELD_W-1:0] div_in,
  output logic               busy,
  output logic               tick
);

  logic               busy_q;
  logic               tick_q;
  logic [FIELD_W-1:0] div_q;
  logic [FIELD_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      tick_q <= 1'b0;
      div_q  <= '0;
      cnt_q  <= '0;
    end else if (start) begin
      busy_q <= 1'b1;
      tick_q <= 1'b0;
      div_q  <= div_in;
      cnt_q  <= '0;
    end else if (stop) begin
      busy_q <= 1'b0;
      tick_q <= 1'b0;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == div_q) begin
        cnt_q  <= '0;
        tick_q <= 1'b1;
      end else begin
        cnt_q  <= cnt_q + 1'b1;
        tick_q <= 1'b0;
      end
    end else begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end
  end

  assign busy = busy_q;
  assign tick = tick_q;

  // R6: latched period holds for the whole access
  a_r6_div_held: assert property (@(posedge clk) disable iff (rst)
    busy_q && !start |=> $stable(div_q));

  // R5: with a nonzero divisor a tick is never followed by another tick
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tick_q && div_q != '0 && !start |=> !tick_q);

  // R7: ending an access silences the tick next cycle
  a_r7_end_quiet: assert property (@(posedge clk) disable iff (rst)
    stop && !start |=> !tick_q && !busy_q);

  // R7: idle with no start means no tick next cycle
  a_r7_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !busy_q && !start |=> !tick_q);

endmodule

// File: rtl/cardtick_wait_sync.sv
module cardtick_wait_sync #(
  parameter int DEPTH = cardtick_pkg::CT_SYNC_DEPTH
) (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic sync_out
);

  logic [DEPTH-1:0] stage_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[0] <= 1'b0;
        else     stage_q[0] <= async_in;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= 1'b0;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign sync_out = stage_q[DEPTH-1];

  // edges seen since reset, saturating, for the latency check
  logic [3:0] seen_q;
  always_ff @(posedge clk) begin
    if (rst)                    seen_q <= '0;
    else if (seen_q != 4'hF)    seen_q <= seen_q + 1'b1;
  end

  // R10: output is the input delayed by DEPTH edges
  a_r10_latency: assert property (@(posedge clk) disable iff (rst)
    (int'(seen_q) >= DEPTH) |-> sync_out == $past(async_in, DEPTH));

endmodule

// File: rtl/cardtick_gen.sv
module cardtick_gen #(
  parameter int FIELD_W    = cardtick_pkg::CT_FIELD_W,
  parameter int N_SPACE    = cardtick_pkg::CT_N_SPACE,
  parameter int N_SLOT     = cardtick_pkg::CT_N_SLOT,
  parameter int SYNC_DEPTH = cardtick_pkg::CT_SYNC_DEPTH,
  localparam int REG_W   = N_SLOT * (N_SPACE * FIELD_W + 1),
  localparam int SLOT_W  = (N_SLOT > 1) ? $clog2(N_SLOT) : 1,
  localparam int SPACE_W = $clog2(N_SPACE + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cfg_wr_en,
  input  logic [REG_W-1:0]   cfg_wdata,
  output logic [REG_W-1:0]   cfg_rdata,
  input  logic               acc_start,
  input  logic               acc_end,
  input  logic [SLOT_W-1:0]  acc_slot,
  input  logic [SPACE_W-1:0] acc_space,
  input  logic               card_wait_in,
  output logic               tick_en,
  output logic               card_wait_out
);

  logic [N_SLOT-1:0][N_SPACE-1:0][FIELD_W-1:0] fields;
  logic [FIELD_W-1:0] sel_div;
  logic               sel_valid;
  logic               start_ok;
  logic               busy;

  cardtick_cfg_reg #(
    .FIELD_W (FIELD_W),
    .N_SPACE (N_SPACE),
    .N_SLOT  (N_SLOT)
  ) u_cfg (
    .clk    (clk),
    .wr_en  (cfg_wr_en),
    .wdata  (cfg_wdata),
    .rdata  (cfg_rdata),
    .fields (fields)
  );

  cardtick_field_sel #(
    .FIELD_W (FIELD_W),
    .N_SPACE (N_SPACE),
    .N_SLOT  (N_SLOT)
  ) u_sel (
    .fields (fields),
    .slot   (acc_slot),
    .space  (acc_space),
    .div    (sel_div),
    .valid  (sel_valid)
  );

  assign start_ok = acc_start & sel_valid;

  cardtick_rate_gen #(
    .FIELD_W (FIELD_W)
  ) u_rate (
    .clk    (clk),
    .rst    (rst),
    .start  (start_ok),
    .stop   (acc_end),
    .div_in (sel_div),
    .busy   (busy),
    .tick   (tick_en)
  );

  cardtick_wait_sync #(
    .DEPTH (SYNC_DEPTH)
  ) u_wait (
    .clk      (clk),
    .rst      (rst),
    .async_in (card_wait_in),
    .sync_out (card_wait_out)
  );

  // R3: reset quiets the outputs
  a_r3_reset_quiet: assert property (@(posedge clk)
    rst |=> !tick_en && !card_wait_out && !busy);

  // R8: an accepted start (even with end) leaves an active access with count cleared
  a_r8_restart: assert property (@(posedge clk) disable iff (rst)
    acc_start && sel_valid |=> busy && !tick_en);

  // R9: invalid space code does not open an access
  a_r9_bad_space: assert property (@(posedge clk) disable iff (rst)
    acc_start && int'(acc_space) >= N_SPACE && !busy |=> !busy && !tick_en);

endmodule

// File: tb/cardtick_gen_test.sv
module cardtick_gen_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr_en = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        acc_start = 1'b0;
  logic        acc_end = 1'b0;
  logic [0:0]  acc_slot = '0;
  logic [1:0]  acc_space = '0;
  logic        card_wait_in = 1'b0;
  logic        tick_en;
  logic        card_wait_out;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;
  bit done     = 1'b0;

  always #4 clk = ~clk;

  cardtick_gen uut (
    .clk(clk), .rst(rst), .cfg_wr_en(cfg_wr_en), .cfg_wdata(cfg_wdata),
    .cfg_rdata(cfg_rdata), .acc_start(acc_start), .acc_end(acc_end),
    .acc_slot(acc_slot), .acc_space(acc_space), .card_wait_in(card_wait_in),
    .tick_en(tick_en), .card_wait_out(card_wait_out)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [31:0] m_reg = '0;
  bit          m_reg_known = 1'b0;
  bit          m_active = 1'b0;
  int          m_div = 0;
  int          m_count = 0;
  bit          m_tick = 1'b0;
  bit          m_wait = 1'b0;
  bit          m_wq[$];

  function automatic int pick(input logic [31:0] w, input int slot, input int space);
    return int'((w >> (slot*16 + space*5)) & 32'h1F);   // R1 layout
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_active = 1'b0; m_count = 0; m_tick = 1'b0;
      m_wq.delete(); m_wq.push_back(1'b0); m_wait = 1'b0;
    end else begin
      if (acc_start && acc_space != 2'd3) begin
        m_active = 1'b1; m_div = pick(m_reg, int'(acc_slot), int'(acc_space));
        m_count = 0; m_tick = 1'b0;
      end else if (acc_end) begin
        m_active = 1'b0; m_count = 0; m_tick = 1'b0;
      end else if (m_active) begin
        m_count++;
        if (m_count == m_div + 1) begin m_tick = 1'b1; m_count = 0; end
        else m_tick = 1'b0;
      end else begin
        m_tick = 1'b0;
      end
      m_wait = m_wq.pop_front();
      m_wq.push_back(card_wait_in);
    end
    if (cfg_wr_en) begin
      m_reg = cfg_wdata & 32'h7FFF_7FFF;
      m_reg_known = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (!rst && !done) begin
      check(tick_en == m_tick, "R5 tick vs model", int'(tick_en), int'(m_tick));
      check(card_wait_out == m_wait, "R10 wait vs model", int'(card_wait_out), int'(m_wait));
      if (m_reg_known)
        check(cfg_rdata == m_reg, "R2 readback vs model", int'(cfg_rdata), int'(m_reg));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick_clk(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic write_word(input logic [31:0] w);
    @(negedge clk); cfg_wr_en = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_wr_en = 1'b0;
  endtask

  task automatic start_acc(input int slot, input int space);
    @(negedge clk); acc_start = 1'b1; acc_slot = 1'(slot); acc_space = 2'(space);
    @(negedge clk); acc_start = 1'b0;
  endtask

  task automatic end_acc();
    @(negedge clk); acc_end = 1'b1;
    @(negedge clk); acc_end = 1'b0;
  endtask

  // cycles until the next tick, counted from the current falling edge
  task automatic until_tick(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_en && n < 100);
  endtask

  function automatic logic [31:0] pack(input int a, b, c, d, e, f);
    return 32'(a) | (32'(b) << 5) | (32'(c) << 10) |
           (32'(d) << 16) | (32'(e) << 21) | (32'(f) << 26);
  endfunction

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    int n;
    int divs[2][3];
    logic [31:0] w;
    divs = '{'{0, 3, 7}, '{12, 20, 31}};

    tick_clk(3);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    check(tick_en == 1'b0, "R3 reset tick", int'(tick_en), 0);
    check(card_wait_out == 1'b0, "R3 reset wait", int'(card_wait_out), 0);

    // R2: reserved bits read zero
    write_word(32'hFFFF_FFFF);
    check(cfg_rdata == 32'h7FFF_7FFF, "R2 reserved masked", int'(cfg_rdata), int'(32'h7FFF_7FFF));

    // R3: reset keeps the word
    w = pack(divs[0][0], divs[0][1], divs[0][2], divs[1][0], divs[1][1], divs[1][2]);
    write_word(w | 32'h8000_8000);
    @(negedge clk); rst = 1'b1;
    tick_clk(2);
    @(negedge clk); rst = 1'b0;
    check(cfg_rdata == w, "R3 word kept through reset", int'(cfg_rdata), int'(w));

    // R7: idle, no ticks
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      check(tick_en == 1'b0, "R7 idle no tick", int'(tick_en), 0);
    end

    // R1 / R4 / R5: every slot and space, first tick and period
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 3; p++) begin
        start_acc(s, p);
        until_tick(n);
        check(n == divs[s][p] + 1, "R1 R4 first tick delay", n, divs[s][p] + 1);
        until_tick(n);
        check(n == divs[s][p] + 1, "R5 tick period", n, divs[s][p] + 1);
        end_acc();
        @(negedge clk);
        check(tick_en == 1'b0, "R7 quiet after end", int'(tick_en), 0);
      end
    end

    // R5: divisor 0 gives a tick every cycle
    start_acc(0, 0);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      check(tick_en == 1'b1, "R5 divisor zero every cycle", int'(tick_en), 1);
    end
    end_acc();

    // R6: write during access does not change the period
    start_acc(1, 0);               // divisor 12
    tick_clk(4);
    write_word(pack(1, 1, 1, 1, 1, 1));
    until_tick(n);
    until_tick(n);
    check(n == 13, "R6 period frozen after write", n, 13);
    end_acc();
    write_word(w);

    // R4: write on the same edge as start uses the old field
    @(negedge clk);
    acc_start = 1'b1; acc_slot = 1'b0; acc_space = 2'd2;   // old divisor 7
    cfg_wr_en = 1'b1; cfg_wdata = pack(0, 0, 2, 0, 0, 0);
    @(negedge clk); acc_start = 1'b0; cfg_wr_en = 1'b0;
    until_tick(n);
    check(n == 8, "R4 same-edge write ignored", n, 8);
    end_acc();
    write_word(w);

    // R8: restart mid access with another field
    start_acc(1, 2);               // divisor 31
    tick_clk(10);
    start_acc(0, 1);               // divisor 3
    until_tick(n);
    check(n == 4, "R8 restart count", n, 4);
    // R8: start together with end, start wins
    @(negedge clk); acc_start = 1'b1; acc_end = 1'b1; acc_slot = 1'b0; acc_space = 2'd2;
    @(negedge clk); acc_start = 1'b0; acc_end = 1'b0;
    until_tick(n);
    check(n == 8, "R8 start beats end", n, 8);
    end_acc();

    // R9: space code 3 ignored
    start_acc(1, 3);
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      check(tick_en == 1'b0, "R9 bad space no tick", int'(tick_en), 0);
    end

    // R10: two-edge latency of the wait line
    @(negedge clk); card_wait_in = 1'b1;
    @(negedge clk);
    check(card_wait_out == 1'b0, "R10 not yet", int'(card_wait_out), 0);
    @(negedge clk);
    check(card_wait_out == 1'b1, "R10 after two edges", int'(card_wait_out), 1);
    for (int i = 0; i < 30; i++) begin
      @(negedge clk); card_wait_in = ((i % 3) == 0) || ((i % 7) == 2);
    end
    @(negedge clk); card_wait_in = 1'b0;
    tick_clk(4);
    check(card_wait_out == 1'b0, "R10 settles low", int'(card_wait_out), 0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule